// File: doc/BRIEF.md
# Store-multiple address sequencer

This block breaks a single store-multiple request into a run of one-word memory writes. A request carries a 32-bit base address, the index of the register that holds the base, a 16-bit mask of the registers to be stored, a 2-bit addressing mode, a writeback flag and a 2-bit encoding class. The block first checks the request against the legality rules of that encoding class. An illegal request is reported with a one-cycle flag and produces no writes.

A legal request produces one write beat per set mask bit. Each beat carries a register index and a word address. Registers go out in ascending index order and addresses rise by 4 bytes per beat, whichever mode is used. A write beat presents `wr_valid` and waits for `wr_ready`. When the beat's register is the base register itself, `wr_use_base` tells the datapath to store the base value from before the instruction.

After the last beat is accepted, `done` pulses once. When writeback was requested, `wb_en` pulses in the same cycle and `wb_value` carries the new base. Register file storage, condition evaluation and the memory itself sit outside the block.

Top module: `stm_seq`

## Requirements
- R1: The mode codes are 0 = increment after, 1 = increment before, 2 = decrement after and 3 = decrement before. For n set mask bits and base B, the first write address is B, B+4, B-4n+4 and B-4n respectively.
- R2: Beats go out in ascending register index order. Each beat's address is 4 above the previous beat's address.
- R3: A beat is consumed only in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_reg`, `wr_addr` and `wr_use_base` hold steady.
- R4: `done` is high for exactly the one cycle after the last beat is accepted. `busy` and `wr_valid` are high from the cycle after an accepted `start` until that last acceptance.
- R5: If writeback was requested, `wb_en` pulses together with `done` and `wb_value` = B+4n for increment modes or B-4n for decrement modes. Without writeback, `wb_en` stays low.
- R6: `wr_use_base` is high exactly on the beat whose `wr_reg` equals the base index.
- R7: If the base register is in the mask and writeback is set, the request is legal only when the base is the lowest set mask bit; otherwise it is illegal.
- R8: A base index of 15 or an all-zero mask makes the request illegal.
- R9: With encoding class 1 (compact), the request is illegal if mask bit 13 or bit 15 is set, if fewer than two mask bits are set, or if the base is in the mask with writeback.
- R10: With encoding class 2 (16-bit), the request is illegal unless mask bits 15..8 are clear, the base index is below 8, the mode is 0 and writeback is set. Encoding class 3 is always illegal; class 0 (full) carries only the common rules.
- R11: An illegal request raises `illegal` for the one cycle after `start`. It produces no write beat, no `done` and no `wb_en`, and the block stays idle.
- R12: `start` is ignored while `busy` is high. The ongoing sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| base_addr | input | 32 | Base address of the request |
| base_idx | input | 4 | Index of the base register |
| reg_mask | input | 16 | Registers to store, bit i = register i |
| mode | input | 2 | Addressing mode (see R1) |
| wback | input | 1 | Write the final address back to the base |
| enc | input | 2 | Encoding class: 0 full, 1 compact, 2 16-bit, 3 reserved |
| busy | output | 1 | Sequence in progress |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_reg | output | 4 | Register index of the beat |
| wr_addr | output | 32 | Word address of the beat |
| wr_use_base | output | 1 | Store the original base value for this beat |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-request pulse |
| wb_en | output | 1 | Base writeback strobe |
| wb_value | output | 32 | New base value |

## Verification
A corrupt remaining-mask register shows up on the next beat. It appears as a skipped or repeated `wr_reg`, or as a `done` pulse that comes too early or too late. A wrong running address appears in `wr_addr` on the first or second beat, because each beat is compared with the bench's own address computation for every mode. A mis-latched base index or final address shows up only at the ends of a sequence: as `wr_use_base` on the wrong beat, or as a wrong `wb_value` in the cycle after the last acceptance. Legality faults are exposed by the `illegal` flag one cycle after `start`.

// File: rtl/stm_seq_pkg.sv
package stm_seq_pkg;
  typedef enum logic [1:0] {
    AM_UP_AFTER  = 2'd0,
    AM_UP_BEFORE = 2'd1,
    AM_DN_AFTER  = 2'd2,
    AM_DN_BEFORE = 2'd3
  } am_e;

  typedef enum logic [1:0] {
    EC_FULL    = 2'd0,
    EC_COMPACT = 2'd1,
    EC_NARROW  = 2'd2,
    EC_RSVD    = 2'd3
  } enc_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;
endpackage

// File: rtl/stm_legal.sv
module stm_legal
  import stm_seq_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int LO_REGS = 8,
  parameter int IDX_W   = $clog2(NREG),
  parameter int CNT_W   = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  mask,
  input  logic [IDX_W-1:0] base_idx,
  input  am_e              mode,
  input  logic             wback,
  input  enc_e             enc,
  output logic [CNT_W-1:0] count,
  output logic             bad
);
  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(NREG - 1);
  localparam int               SP_POS = NREG - 3;

  logic [NREG-1:0] below;
  logic            hi_used;
  logic            base_in, base_low;
  logic            bad_common, bad_compact, bad_narrow;

  always_comb begin
    count   = '0;
    hi_used = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      count    = count + CNT_W'(mask[i]);
      below[i] = mask[i] && (IDX_W'(i) < base_idx);
      if (i >= LO_REGS) hi_used = hi_used | mask[i];
    end
  end

  assign base_in  = mask[base_idx];
  assign base_low = base_in && (below == '0);

  assign bad_common  = (mask == '0) || (base_idx == PC_IDX) ||
                       (wback && base_in && !base_low);
  assign bad_compact = mask[SP_POS] || mask[NREG-1] ||
                       (count < CNT_W'(2)) || (wback && base_in);
  assign bad_narrow  = hi_used || (base_idx >= IDX_W'(LO_REGS)) ||
                       (mode != AM_UP_AFTER) || !wback;

  always_comb begin
    case (enc)
      EC_FULL:    bad = bad_common;
      EC_COMPACT: bad = bad_common || bad_compact;
      EC_NARROW:  bad = bad_common || bad_narrow;
      default:    bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/stm_addr_gen.sv
module stm_addr_gen
  import stm_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  input  am_e               mode,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] final_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] span, low;

  assign span = ADDR_W'(count) * STEP;
  assign low  = base - span;

  always_comb begin
    case (mode)
      AM_UP_AFTER:  begin first_addr = base;        final_addr = base + span; end
      AM_UP_BEFORE: begin first_addr = base + STEP; final_addr = base + span; end
      AM_DN_AFTER:  begin first_addr = low + STEP;  final_addr = low;         end
      default:      begin first_addr = low;         final_addr = low;         end
    endcase
  end
endmodule

// File: rtl/stm_pick.sv
module stm_pick #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  pend,
  output logic [IDX_W-1:0] idx,
  output logic [NREG-1:0]  clr
);
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
    clr = pend & ~(NREG'(1) << idx);
  end
endmodule

// File: rtl/stm_seq.sv
module stm_seq
  import stm_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int LO_REGS    = 8,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(NREG),
  localparam int CNT_W     = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [NREG-1:0]   reg_mask,
  input  logic [1:0]        mode,
  input  logic              wback,
  input  logic [1:0]        enc,
  output logic              busy,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IDX_W-1:0]  wr_reg,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_use_base,
  output logic              done,
  output logic              illegal,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [CNT_W-1:0]  req_cnt;
  logic              req_bad;
  logic [ADDR_W-1:0] req_first, req_final;

  stm_legal #(.NREG(NREG), .LO_REGS(LO_REGS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_legal (
    .mask     (reg_mask),
    .base_idx (base_idx),
    .mode     (am_e'(mode)),
    .wback    (wback),
    .enc      (enc_e'(enc)),
    .count    (req_cnt),
    .bad      (req_bad)
  );

  stm_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base       (base_addr),
    .count      (req_cnt),
    .mode       (am_e'(mode)),
    .first_addr (req_first),
    .final_addr (req_final)
  );

  st_e               state_q, state_d;
  logic              done_q, done_d;
  logic              ill_q, ill_d;
  logic [NREG-1:0]   rem_q, rem_d, rem_next;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  base_q;
  logic [ADDR_W-1:0] final_q;
  logic              wb_q;
  logic [IDX_W-1:0]  cur_idx;
  logic              take, fire, seq_en, cfg_en;

  stm_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .pend (rem_q),
    .idx  (cur_idx),
    .clr  (rem_next)
  );

  assign take   = start && (state_q == ST_IDLE);
  assign fire   = (state_q == ST_RUN) && wr_ready;
  assign cfg_en = take && !req_bad;
  assign seq_en = cfg_en || fire;

  // next-state logic
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    ill_d   = take && req_bad;
    case (state_q)
      ST_IDLE: begin
        if (cfg_en) begin
          state_d = ST_RUN;
          rem_d   = reg_mask;
          addr_d  = req_first;
        end
      end
      default: begin
        if (fire) begin
          rem_d  = rem_next;
          addr_d = addr_q + STEP;
          if (rem_next == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      ill_q   <= ill_d;
    end
  end

  // sequence datapath registers
  always_ff @(posedge clk) begin
    if (seq_en) begin
      rem_q  <= rem_d;
      addr_q <= addr_d;
    end
  end

  // request attributes latched once per accepted request
  always_ff @(posedge clk) begin
    if (cfg_en) begin
      base_q  <= base_idx;
      final_q <= req_final;
      wb_q    <= wback;
    end
  end

  assign busy        = (state_q == ST_RUN);
  assign wr_valid    = busy;
  assign wr_reg      = cur_idx;
  assign wr_addr     = addr_q;
  assign wr_use_base = busy && (cur_idx == base_q);
  assign done        = done_q;
  assign illegal     = ill_q;
  assign wb_en       = done_q && wb_q;
  assign wb_value    = final_q;
endmodule

// File: rtl/stm_seq_chk.sv
module stm_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [IDX_W-1:0]  wr_reg,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_use_base,
  input logic              done,
  input logic              illegal,
  input logic              wb_en
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + ADDR_W'(4))));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || (wr_reg > $past(wr_reg))));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_reg) && $stable(wr_addr) && $stable(wr_use_base)));

  p_done_after_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_valid && wr_ready) && !wr_valid));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_wb_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wr_valid && !done && !wb_en && $past(start && !busy)));

  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !wr_ready) |=> (busy && $stable(wr_reg) && $stable(wr_addr)));
endmodule

bind stm_seq stm_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_reg      (wr_reg),
  .wr_addr     (wr_addr),
  .wr_use_base (wr_use_base),
  .done        (done),
  .illegal     (illegal),
  .wb_en       (wb_en)
);

// File: tb/stm_seq_tb.sv
module stm_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] base_addr;
  logic [3:0]  base_idx;
  logic [15:0] reg_mask;
  logic [1:0]  mode;
  logic        wback;
  logic [1:0]  enc;
  logic        busy, wr_valid, wr_ready, wr_use_base, done, illegal, wb_en;
  logic [3:0]  wr_reg;
  logic [31:0] wr_addr, wb_value;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #5 clk = ~clk;

  stm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .base_idx(base_idx), .reg_mask(reg_mask), .mode(mode), .wback(wback),
    .enc(enc), .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_reg(wr_reg), .wr_addr(wr_addr), .wr_use_base(wr_use_base),
    .done(done), .illegal(illegal), .wb_en(wb_en), .wb_value(wb_value)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, act=%0d exp<=20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic drive(input logic [31:0] b, input logic [3:0] bi, input logic [15:0] m,
                       input logic [1:0] md, input logic wb, input logic [1:0] ec);
    @(negedge clk);
    base_addr = b; base_idx = bi; reg_mask = m; mode = md; wback = wb; enc = ec;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // legal request: every beat, completion and writeback checked
  task automatic run_ok(input string req, input logic [31:0] b, input logic [3:0] bi,
                        input logic [15:0] m, input logic [1:0] md, input logic wb,
                        input logic [1:0] ec, input bit stall);
    int n = ones(m);
    int k = 0;
    logic [31:0] a0, fin;
    case (md)
      2'd0: begin a0 = b;                  fin = b + 32'(4*n); end
      2'd1: begin a0 = b + 32'd4;          fin = b + 32'(4*n); end
      2'd2: begin a0 = b - 32'(4*n) + 32'd4; fin = b - 32'(4*n); end
      default: begin a0 = b - 32'(4*n);    fin = b - 32'(4*n); end
    endcase
    drive(b, bi, m, md, wb, ec);
    chk(illegal == 1'b0 && busy == 1'b1, {req, " R4 busy after start"}, {busy, illegal}, 2'b10);
    for (int r = 0; r < 16; r++) begin
      if (m[r]) begin
        if (stall && (k % 2 == 1)) begin
          wr_ready = 1'b0;
          @(negedge clk);
          chk(wr_valid && wr_reg == 4'(r) && wr_addr == a0 + 32'(4*k),
              {req, " R3 beat held while not ready"}, wr_addr, a0 + 32'(4*k));
        end
        wr_ready = 1'b1;
        chk(wr_valid && wr_reg == 4'(r), {req, " R2 register order"}, {28'd0, wr_reg}, r);
        chk(wr_addr == a0 + 32'(4*k), {req, " R1 R2 beat address"}, wr_addr, a0 + 32'(4*k));
        chk(wr_use_base == (4'(r) == bi), {req, " R6 base substitution"}, wr_use_base, (4'(r) == bi));
        chk(done == 1'b0, {req, " R4 no early done"}, done, 0);
        @(negedge clk);
        k++;
      end
    end
    wr_ready = 1'b0;
    chk(done && !wr_valid && !busy, {req, " R4 done after last beat"}, {done, wr_valid, busy}, 3'b100);
    chk(wb_en == wb, {req, " R5 writeback strobe"}, wb_en, wb);
    if (wb) chk(wb_value == fin, {req, " R5 writeback value"}, wb_value, fin);
    @(negedge clk);
    chk(!done && !wb_en, {req, " R4 done is one cycle"}, {done, wb_en}, 0);
  endtask

  task automatic run_bad(input string req, input logic [31:0] b, input logic [3:0] bi,
                         input logic [15:0] m, input logic [1:0] md, input logic wb,
                         input logic [1:0] ec);
    wr_ready = 1'b1;
    drive(b, bi, m, md, wb, ec);
    chk(illegal == 1'b1, {req, " illegal flagged"}, illegal, 1);
    chk(!wr_valid && !done && !wb_en && !busy, {req, " R11 no writes on illegal"},
        {wr_valid, done, wb_en, busy}, 0);
    @(negedge clk);
    chk(!illegal && !wr_valid && !done, {req, " R11 illegal is one cycle"}, {illegal, wr_valid, done}, 0);
    wr_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy && !wr_valid && !done && !illegal && !wb_en, "R4 reset state",
        {busy, wr_valid, done, illegal, wb_en}, 0);
  endtask

  task automatic t_modes();
    run_ok("R1 up-after",    32'h0000_1000, 4'd0, 16'h0F0A, 2'd0, 1'b1, 2'd0, 1'b0);
    run_ok("R1 up-before",   32'h0000_2000, 4'd7, 16'h00F0, 2'd1, 1'b0, 2'd0, 1'b1);
    run_ok("R1 down-after",  32'h0000_3000, 4'd14, 16'h8421, 2'd2, 1'b1, 2'd0, 1'b1);
    run_ok("R1 down-before", 32'h0000_4000, 4'd1, 16'h1878, 2'd3, 1'b1, 2'd0, 1'b0);
    run_ok("R5 no writeback", 32'h0000_0010, 4'd3, 16'h8001, 2'd3, 1'b0, 2'd0, 1'b1);
  endtask

  task automatic t_base_in_list();
    run_ok("R7 base lowest with writeback", 32'h0000_5000, 4'd2, 16'h0034, 2'd0, 1'b1, 2'd0, 1'b1);
    run_ok("R6 base not lowest no writeback", 32'h0000_6000, 4'd5, 16'h0230, 2'd1, 1'b0, 2'd0, 1'b0);
    run_bad("R7 base not lowest with writeback", 32'h0000_6000, 4'd5, 16'h0230, 2'd0, 1'b1, 2'd0);
  endtask

  task automatic t_common_bad();
    run_bad("R8 base index 15", 32'h0000_7000, 4'd15, 16'h0006, 2'd0, 1'b0, 2'd0);
    run_bad("R8 empty mask",    32'h0000_7000, 4'd1,  16'h0000, 2'd0, 1'b0, 2'd0);
  endtask

  task automatic t_compact();
    run_bad("R9 reg 13 listed", 32'h0000_8000, 4'd0, 16'h2006, 2'd0, 1'b0, 2'd1);
    run_bad("R9 reg 15 listed", 32'h0000_8000, 4'd0, 16'h8006, 2'd0, 1'b0, 2'd1);
    run_bad("R9 single reg",    32'h0000_8000, 4'd0, 16'h0040, 2'd0, 1'b0, 2'd1);
    run_bad("R9 base listed with writeback", 32'h0000_8000, 4'd1, 16'h0006, 2'd0, 1'b1, 2'd1);
    run_ok("R9 compact legal", 32'h0000_8000, 4'd0, 16'h1002, 2'd3, 1'b1, 2'd1, 1'b0);
  endtask

  task automatic t_narrow();
    run_ok("R10 narrow legal", 32'h0000_9000, 4'd3, 16'h00C1, 2'd0, 1'b1, 2'd2, 1'b1);
    run_bad("R10 high reg",       32'h0000_9000, 4'd3, 16'h0101, 2'd0, 1'b1, 2'd2);
    run_bad("R10 high base",      32'h0000_9000, 4'd8, 16'h0003, 2'd0, 1'b1, 2'd2);
    run_bad("R10 wrong mode",     32'h0000_9000, 4'd3, 16'h0003, 2'd3, 1'b1, 2'd2);
    run_bad("R10 no writeback",   32'h0000_9000, 4'd3, 16'h0003, 2'd0, 1'b0, 2'd2);
    run_bad("R10 reserved class", 32'h0000_9000, 4'd3, 16'h0003, 2'd0, 1'b1, 2'd3);
  endtask

  task automatic t_busy_ignore();
    wr_ready = 1'b0;
    drive(32'h0000_A000, 4'd0, 16'h0006, 2'd0, 1'b1, 2'd0);
    chk(wr_valid && wr_reg == 4'd1 && wr_addr == 32'h0000_A000, "R12 first beat", wr_addr, 32'h0000_A000);
    base_addr = 32'h0000_0F00; reg_mask = 16'h0800; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(wr_valid && wr_reg == 4'd1 && wr_addr == 32'h0000_A000 && !illegal,
        "R12 start ignored while busy", wr_addr, 32'h0000_A000);
    wr_ready = 1'b1;
    @(negedge clk);
    chk(wr_valid && wr_reg == 4'd2 && wr_addr == 32'h0000_A004, "R12 second beat", wr_addr, 32'h0000_A004);
    @(negedge clk);
    wr_ready = 1'b0;
    chk(done && wb_en && wb_value == 32'h0000_A008, "R12 R5 original request completes", wb_value, 32'h0000_A008);
    @(negedge clk);
    chk(!busy && !wr_valid, "R12 no second sequence", {busy, wr_valid}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_ready = 1'b0;
    base_addr = '0; base_idx = '0; reg_mask = '0; mode = '0; wback = 1'b0; enc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_modes();
    t_base_in_list();
    t_common_bad();
    t_compact();
    t_narrow();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule